// File: doc/BRIEF.md
# Serial Data Link Frame Receiver

This block rebuilds fixed-format frames from a serial real-time broadcast link. A recovered data line is sampled only on cycles where a bit-enable strobe is high. The carrier recovery in front of the block produces that strobe. Each frame opens with a low start bit. Next come an 8-bit address field and a 24-bit data word, and the frame closes with an 8-bit check value. Every field is sent most-significant bit first.

The receiver computes a CRC-8 over the 32 address and data bits and compares it with the received check value. When they match, the address and data are published with a one-clock valid strobe. When they differ, the block raises a one-clock beam-abort pulse and sets a sticky error flag, and a saturating counter records the event.

If the bit strobes stop in the middle of a frame for longer than a set number of bit periods, the partial frame is dropped. That event raises a framing-error pulse and is counted separately.

Top module: `serial_frame_rx`

## Requirements
- R1: After synchronous reset, frame_valid, crc_abort, framing_err and crc_err_flag are 0, frame_addr and frame_data are 0, and both counters are 0.
- R2: While waiting for a frame, a bit strobe with line_in at 0 is taken as the start bit. The next 40 strobes carry the address (8 bits), then the data (24 bits), then the check value (8 bits), each field MSB first.
- R3: The check value is CRC-8 with polynomial 0x07 (x^8+x^2+x+1) and initial value 0x00, computed MSB first over the 32 address and data bits. When it matches, frame_valid is high for exactly one clock, in the cycle after the clock edge that samples the last check bit.
- R4: frame_addr and frame_data change only together with a frame_valid pulse. They hold the last good frame's fields until the next good frame.
- R5: When the check value differs, crc_abort is high for exactly one clock, in the cycle after the last check bit, and frame_valid stays low for that frame.
- R6: crc_err_flag is set by a check mismatch and stays set until err_clear is sampled high. If a mismatch and err_clear occur in the same cycle, the flag ends up set.
- R7: crc_err_count increments by one on each check mismatch and saturates at 2^CNT_W-1.
- R8: Mid-frame, if more than GAP_BITS*BIT_CLKS consecutive clocks pass without a bit strobe, the partial frame is dropped. framing_err is then high for one clock, neither frame_valid nor crc_abort is raised for that frame, and the receiver waits for a new start bit.
- R9: A pause of exactly GAP_BITS*BIT_CLKS clocks without a strobe between two bits of a frame is tolerated, and the frame is received normally.
- R10: framing_err_count increments by one on each dropped partial frame and saturates at 2^CNT_W-1.
- R11: While waiting for a frame, strobes with line_in at 1 are ignored and produce no output event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit strobe; line_in is sampled when high |
| line_in | input | 1 | Serial data line, idles high |
| err_clear | input | 1 | Clears the sticky check-error flag |
| frame_valid | output | 1 | One-clock strobe for a good frame |
| frame_addr | output | 8 | Address of the last good frame |
| frame_data | output | 24 | Data word of the last good frame |
| crc_abort | output | 1 | One-clock beam-abort pulse on a check mismatch |
| crc_err_flag | output | 1 | Sticky check-error flag |
| framing_err | output | 1 | One-clock pulse when a partial frame is dropped |
| crc_err_count | output | CNT_W | Saturating count of check mismatches |
| framing_err_count | output | CNT_W | Saturating count of dropped partial frames |

## Verification
The bench builds the receiver with BIT_CLKS=4 and GAP_BITS=2, so the strobe-gap limit is 8 clocks. This makes it cheap to place strobes exactly at the limit and one clock beyond it. CNT_W is set to 3, so eight corrupted frames drive the check-error counter into saturation at 7. At the 16-bit default that would take far more frames than the run allows.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 24;
    localparam int CRC_W     = 8;
    localparam int PAYLOAD_W = ADDR_W + DATA_W;
    localparam int BODY_W    = PAYLOAD_W + CRC_W;
    localparam int BITCNT_W  = $clog2(BODY_W);
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

    typedef enum logic {
        ST_HUNT,
        ST_BODY
    } rx_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                  input logic bit_in);
        logic fb;
        fb = cur[CRC_W-1] ^ bit_in;
        return {cur[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/sfr_crc_acc.sv
module sfr_crc_acc
    import sfr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             en,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc <= '0;
        end else if (en) begin
            crc <= crc_step(crc, bit_in);
        end
    end

endmodule

// File: rtl/sfr_gap_timer.sv
module sfr_gap_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic strobe,
    output logic timeout
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] idle_cnt;

    assign timeout = active && !strobe && (idle_cnt == CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || !active || strobe) begin
            idle_cnt <= '0;
        end else if (idle_cnt != CW'(LIMIT)) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sfr_sat_counter.sv
module sfr_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc && (count != {W{1'b1}})) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
    import sfr_pkg::*;
#(
    parameter int BIT_CLKS = 4,
    parameter int GAP_BITS = 2,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              line_in,
    input  logic              err_clear,
    output logic              frame_valid,
    output logic [ADDR_W-1:0] frame_addr,
    output logic [DATA_W-1:0] frame_data,
    output logic              crc_abort,
    output logic              crc_err_flag,
    output logic              framing_err,
    output logic [CNT_W-1:0]  crc_err_count,
    output logic [CNT_W-1:0]  framing_err_count
);

    localparam int GAP_LIMIT = GAP_BITS * BIT_CLKS;

    rx_state_e            state;
    logic [BITCNT_W-1:0]  bit_cnt;
    logic [BODY_W-2:0]    shreg;
    logic [CRC_W-1:0]     crc_calc;
    logic [CRC_W-1:0]     crc_rx;
    frame_t               frame_now;
    frame_t               frame_q;
    logic                 in_body;
    logic                 last_bit;
    logic                 crc_match;
    logic                 gap_timeout;
    logic                 crc_en;

    assign in_body   = (state == ST_BODY);
    assign last_bit  = in_body && bit_en && (bit_cnt == BITCNT_W'(BODY_W - 1));
    assign crc_rx    = {shreg[CRC_W-2:0], line_in};
    assign crc_match = (crc_rx == crc_calc);
    assign frame_now = frame_t'(shreg[BODY_W-2:CRC_W-1]);
    assign crc_en    = in_body && bit_en && (bit_cnt < BITCNT_W'(PAYLOAD_W));

    sfr_crc_acc u_crc (
        .clk    (clk),
        .rst    (rst),
        .clear  (!in_body),
        .en     (crc_en),
        .bit_in (line_in),
        .crc    (crc_calc)
    );

    sfr_gap_timer #(
        .LIMIT (GAP_LIMIT)
    ) u_gap (
        .clk     (clk),
        .rst     (rst),
        .active  (in_body),
        .strobe  (bit_en),
        .timeout (gap_timeout)
    );

    // receive sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_HUNT;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            case (state)
                ST_HUNT: begin
                    if (bit_en && !line_in) begin
                        state   <= ST_BODY;
                        bit_cnt <= '0;
                    end
                end
                ST_BODY: begin
                    if (gap_timeout || last_bit) begin
                        state <= ST_HUNT;
                    end else if (bit_en) begin
                        shreg   <= {shreg[BODY_W-3:0], line_in};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    // result stage
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_valid  <= 1'b0;
            crc_abort    <= 1'b0;
            framing_err  <= 1'b0;
            crc_err_flag <= 1'b0;
            frame_q      <= '0;
        end else begin
            frame_valid <= last_bit && crc_match;
            crc_abort   <= last_bit && !crc_match;
            framing_err <= gap_timeout;
            if (last_bit && crc_match) begin
                frame_q <= frame_now;
            end
            if (last_bit && !crc_match) begin
                crc_err_flag <= 1'b1;
            end else if (err_clear) begin
                crc_err_flag <= 1'b0;
            end
        end
    end

    assign frame_addr = frame_q.addr;
    assign frame_data = frame_q.data;

    sfr_sat_counter #(
        .W (CNT_W)
    ) u_crc_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (last_bit && !crc_match),
        .count (crc_err_count)
    );

    sfr_sat_counter #(
        .W (CNT_W)
    ) u_frm_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (gap_timeout),
        .count (framing_err_count)
    );

endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_valid,
    input logic [7:0]       frame_addr,
    input logic [23:0]      frame_data,
    input logic             crc_abort,
    input logic             crc_err_flag,
    input logic             framing_err,
    input logic [CNT_W-1:0] crc_err_count,
    input logic [CNT_W-1:0] framing_err_count
);

    assert_valid_single_R3: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);

    assert_abort_single_R5: assert property (@(posedge clk) disable iff (rst)
        crc_abort |=> !crc_abort);

    assert_abort_no_valid_R5: assert property (@(posedge clk) disable iff (rst)
        !(crc_abort && frame_valid));

    assert_fields_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |-> ($stable(frame_addr) && $stable(frame_data)));

    assert_flag_follows_abort_R6: assert property (@(posedge clk) disable iff (rst)
        crc_abort |-> crc_err_flag);

    assert_crc_count_monotone_R7: assert property (@(posedge clk) disable iff (rst)
        crc_err_count >= $past(crc_err_count));

    assert_frame_count_monotone_R10: assert property (@(posedge clk) disable iff (rst)
        framing_err_count >= $past(framing_err_count));

    assert_drop_no_result_R8: assert property (@(posedge clk) disable iff (rst)
        framing_err |-> (!frame_valid && !crc_abort));

endmodule

bind serial_frame_rx serial_frame_rx_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk               (clk),
    .rst               (rst),
    .frame_valid       (frame_valid),
    .frame_addr        (frame_addr),
    .frame_data        (frame_data),
    .crc_abort         (crc_abort),
    .crc_err_flag      (crc_err_flag),
    .framing_err       (framing_err),
    .crc_err_count     (crc_err_count),
    .framing_err_count (framing_err_count)
);

// File: tb/tb_serial_frame_rx.sv
module tb_serial_frame_rx;

    localparam int BIT_CLKS = 4;
    localparam int GAP_BITS = 2;
    localparam int CNT_W    = 3;
    localparam int LIMIT    = BIT_CLKS * GAP_BITS;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bit_en = 1'b0;
    logic             line_in = 1'b1;
    logic             err_clear = 1'b0;
    logic             frame_valid;
    logic [7:0]       frame_addr;
    logic [23:0]      frame_data;
    logic             crc_abort;
    logic             crc_err_flag;
    logic             framing_err;
    logic [CNT_W-1:0] crc_err_count;
    logic [CNT_W-1:0] framing_err_count;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // expected event: kind 0 good, 1 check mismatch, 2 dropped
    typedef struct {
        int          kind;
        logic [7:0]  addr;
        logic [23:0] data;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    serial_frame_rx #(
        .BIT_CLKS (BIT_CLKS),
        .GAP_BITS (GAP_BITS),
        .CNT_W    (CNT_W)
    ) dut (
        .clk               (clk),
        .rst               (rst),
        .bit_en            (bit_en),
        .line_in           (line_in),
        .err_clear         (err_clear),
        .frame_valid       (frame_valid),
        .frame_addr        (frame_addr),
        .frame_data        (frame_data),
        .crc_abort         (crc_abort),
        .crc_err_flag      (crc_err_flag),
        .framing_err       (framing_err),
        .crc_err_count     (crc_err_count),
        .framing_err_count (framing_err_count)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // remainder of {payload, 8'h00} divided by x^8+x^2+x+1
    function automatic logic [7:0] ref_crc(input logic [31:0] payload);
        logic [39:0] r;
        r = {payload, 8'h00};
        for (int i = 39; i >= 8; i--) begin
            if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
        end
        return r[7:0];
    endfunction

    task automatic send_bit(input logic b, input int gap);
        @(negedge clk);
        line_in = b;
        bit_en  = 1'b1;
        @(negedge clk);
        bit_en  = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] a, input logic [23:0] d,
                              input logic [7:0] crc_flip, input int gap);
        logic [39:0] body;
        exp_t e;
        body = {a, d, ref_crc({a, d}) ^ crc_flip};
        e.kind = (crc_flip != 0) ? 1 : 0;
        e.addr = a;
        e.data = d;
        exp_q.push_back(e);
        send_bit(1'b0, gap);
        for (int i = 39; i >= 0; i--) send_bit(body[i], gap);
        line_in = 1'b1;
    endtask

    task automatic send_partial(input int nbits);
        exp_t e;
        e.kind = 2;
        e.addr = '0;
        e.data = '0;
        exp_q.push_back(e);
        send_bit(1'b0, BIT_CLKS - 1);
        for (int i = 0; i < nbits; i++) send_bit(i[0], BIT_CLKS - 1);
        line_in = 1'b1;
        repeat (LIMIT + 6) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && (frame_valid || crc_abort || framing_err)) begin
            int k;
            k = frame_valid ? 0 : (crc_abort ? 1 : 2);
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected event", k, 99);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(k == e.kind, "R3/R5/R8 event kind", k, e.kind);
                if (e.kind == 0) begin
                    check(frame_addr == e.addr, "R2 R4 frame_addr", frame_addr, e.addr);
                    check(frame_data == e.data, "R2 R4 frame_data", frame_data, e.data);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!frame_valid && !crc_abort && !framing_err && !crc_err_flag,
              "R1 strobes", {frame_valid, crc_abort, framing_err, crc_err_flag}, 0);
        check(frame_addr == 0 && frame_data == 0, "R1 fields", {frame_addr, frame_data}, 0);
        check(crc_err_count == 0 && framing_err_count == 0, "R1 counters",
              {crc_err_count, framing_err_count}, 0);

        // R11 idle strobes with high line
        for (int i = 0; i < 20; i++) send_bit(1'b1, BIT_CLKS - 1);
        repeat (4) @(negedge clk);
        check(frame_addr == 0 && crc_err_count == 0 && framing_err_count == 0,
              "R11 idle ignored", {frame_addr, crc_err_count}, 0);

        // R2 R3 good frames with varied patterns
        send_frame(8'hA5, 24'h123456, 8'h00, BIT_CLKS - 1);
        send_frame(8'hFF, 24'hFFFFFF, 8'h00, BIT_CLKS - 1);
        send_frame(8'h00, 24'h000000, 8'h00, BIT_CLKS - 1);
        send_frame(8'h3C, 24'h80_0001, 8'h00, BIT_CLKS - 1);
        repeat (4) @(negedge clk);
        check(crc_err_count == 0, "R3 no false mismatch", crc_err_count, 0);

        // R9 gap exactly at the limit
        send_frame(8'h5A, 24'hC0FFEE, 8'h00, LIMIT);
        repeat (4) @(negedge clk);
        check(frame_data == 24'hC0FFEE, "R9 gap at limit", frame_data, 24'hC0FFEE);

        // R5 R6 mismatch
        send_frame(8'h11, 24'h222222, 8'h01, BIT_CLKS - 1);
        repeat (2) @(negedge clk);
        check(crc_err_flag == 1'b1, "R6 flag set", crc_err_flag, 1);
        check(crc_err_count == 1, "R7 count one", crc_err_count, 1);
        check(frame_addr == 8'h5A && frame_data == 24'hC0FFEE, "R4 bad frame keeps fields",
              frame_data, 24'hC0FFEE);
        check(crc_err_flag == 1'b1, "R6 flag sticky", crc_err_flag, 1);
        @(negedge clk);
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        check(crc_err_flag == 1'b0, "R6 flag cleared", crc_err_flag, 0);

        // R8 dropped partial frames, including one gap beyond the limit
        send_partial(10);
        check(framing_err_count == 1, "R10 count one", framing_err_count, 1);
        begin
            exp_t e;
            e.kind = 2; e.addr = '0; e.data = '0;
            exp_q.push_back(e);
            send_bit(1'b0, BIT_CLKS - 1);
            send_bit(1'b1, LIMIT + 1);
            line_in = 1'b1;
            repeat (LIMIT + 4) @(negedge clk);
        end
        check(framing_err_count == 2, "R8 gap beyond limit", framing_err_count, 2);
        send_frame(8'h77, 24'hABCDEF, 8'h00, BIT_CLKS - 1);
        repeat (4) @(negedge clk);
        check(frame_addr == 8'h77, "R8 recovers after drop", frame_addr, 8'h77);

        // R7 saturation
        for (int i = 0; i < 8; i++) send_frame(8'(i), 24'(i * 3), 8'h80, BIT_CLKS - 1);
        repeat (4) @(negedge clk);
        check(crc_err_count == 3'd7, "R7 saturates", crc_err_count, 7);

        // R6 mismatch wins over clear in the same cycle
        begin
            exp_t e;
            logic [39:0] body;
            e.kind = 1; e.addr = 8'h42; e.data = 24'h4242;
            exp_q.push_back(e);
            body = {8'h42, 24'h004242, ref_crc({8'h42, 24'h004242}) ^ 8'h10};
            @(negedge clk);
            err_clear = 1'b1;
            @(negedge clk);
            err_clear = 1'b0;
            check(crc_err_flag == 1'b0, "R6 clear before collision", crc_err_flag, 0);
            send_bit(1'b0, BIT_CLKS - 1);
            for (int i = 39; i >= 1; i--) send_bit(body[i], BIT_CLKS - 1);
            @(negedge clk);
            line_in   = body[0];
            bit_en    = 1'b1;
            err_clear = 1'b1;
            @(negedge clk);
            bit_en    = 1'b0;
            err_clear = 1'b0;
            line_in   = 1'b1;
            check(crc_err_flag == 1'b1, "R6 set wins over clear", crc_err_flag, 1);
        end

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R3 all expected events seen", exp_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule